// File: doc/BRIEF.md
# Vectoring CORDIC Phase and Magnitude Detector

This block takes one complex sample per clock, an in-phase value and a quadrature value, and returns its polar form: the angle as a signed fraction of half a turn and the vector length. It is intended as the phase-error source in a carrier tracking loop. It can also turn an autocorrelation peak into a frequency-offset estimate, or measure the common rotation of pilot tones. Samples enter with a valid strobe. Each result leaves with its own valid strobe a fixed number of cycles later, and a new sample may be accepted on every clock.

Internally, the design is a fully pipelined shift-and-add vector rotator. In each iteration it turns the vector toward the positive real axis and adds the elementary angle used to the angle register. The elementary angles are stored already divided by π, so the angle comes out in normalized units and no scaling multiply is needed. Before the iterations start, any sample in the left half-plane is mirrored through the origin. The angle register is then preset to plus or minus one half-turn, which lets the whole circle converge. A build option removes the rotator's length gain with five shift-and-add steps, so the magnitude is reported in input units. Without that option, the magnitude keeps the gain of about 1.6468.

Top module: `cordic_phase_det`

## Requirements
- R1: Every sample accepted with `in_valid` high yields exactly one result with `out_valid` high exactly ITER+2 clock cycles later (20 with defaults), in the order the samples were accepted.
- R2: `out_phase` is signed, PW bits wide, with 2^(PW-2) meaning +π (65536 with defaults). For any input whose length is at least 4096, it equals atan2(Q, I)/π · 2^(PW-2) within 2 LSB.
- R3: Inputs with a negative in-phase part are resolved over the full circle, including the most negative code -2^(IW-1) on either or both inputs, with the same R2 accuracy.
- R4: A sample on the negative real axis (I < 0, Q = 0) yields a positive phase within 2 LSB of +2^(PW-2), never a value near -2^(PW-2).
- R5: The sample (0, 0) yields `out_phase` = 0 and `out_mag` = 0 exactly.
- R6: With MAG_SCALE = 0, `out_mag` equals K·√(I²+Q²), where K = Π over i=0..ITER-1 of √(1+2^-2i), within 2 + 1/4096 of the expected value.
- R7: With MAG_SCALE = 1, `out_mag` equals √(I²+Q²)·K·(½)(1+¼)(1−1/32)(1+1/256)(1−1/1024) within the same tolerance as R6.
- R8: While `rst_n` is low, `out_valid` is 0.
- R9: Samples presented on consecutive cycles, with or without idle gaps, each produce their own correct result with no loss or reordering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears the valid pipeline |
| in_valid | input | 1 | Marks `in_i`/`in_q` as a sample this cycle |
| in_i | input | IW | In-phase part, signed |
| in_q | input | IW | Quadrature part, signed |
| out_valid | output | 1 | Marks `out_phase`/`out_mag` as a result |
| out_phase | output | PW | Angle, signed, 2^(PW-2) = π |
| out_mag | output | IW+2 | Vector length, unsigned, in input LSBs (gain-scaled unless MAG_SCALE = 1) |

## Verification
The bench targets inputs that break simple vectoring designs. A sample on the negative real axis exposes a fold that picks the wrong sign, which would report −π instead of +π. The most negative codes exercise the fold negation: without a guard bit it would overflow and give an angle off by a half-turn. A (0, 0) sample catches a rotator that lets the angle drift while y stays zero. The samples just above and below the negative axis check that the ±π seam is crossed with the correct sign. Random vectors in all four quadrants, sent back to back and with gaps, check accuracy, magnitude gain and exact latency against an atan2/sqrt model; a stage-count or shift error there shows up as a latency slip or a phase error of many LSB.

// File: rtl/cordic_phase_det.sv
module cordic_phase_det #(
  parameter int IW        = 16,
  parameter int PW        = 18,
  parameter int ITER      = 18,
  parameter int GB        = 10,
  parameter int ZG        = 4,
  parameter int MAG_SCALE = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_i,
  input  logic signed [IW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [PW-1:0] out_phase,
  output logic [IW+1:0]        out_mag
);
  localparam int XW = IW + 3 + GB;
  localparam int ZF = PW - 2 + ZG;
  localparam int ZW = ZF + 2;
  localparam int MW = IW + 2;
  localparam real PI = 3.14159265358979323846;
  localparam logic signed [ZW-1:0] Z_ONE = ZW'(2**ZF);
  localparam logic signed [ZW-1:0] ZRND  = ZW'(2**(ZG-1));
  localparam logic signed [XW-1:0] XRND  = XW'(2**(GB-1));

  logic signed [XW-1:0] ie, qe;
  logic                 lhp;
  assign ie  = XW'(in_i) <<< GB;
  assign qe  = XW'(in_q) <<< GB;
  assign lhp = in_i[IW-1];

  logic signed [XW-1:0] x0, y0;
  logic signed [ZW-1:0] z0;
  logic                 v0, zf0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) v0 <= 1'b0;
    else        v0 <= in_valid;

  always_ff @(posedge clk) begin
    x0  <= lhp ? -ie : ie;
    y0  <= lhp ? -qe : qe;
    z0  <= !lhp ? '0 : (in_q[IW-1] ? -Z_ONE : Z_ONE);
    zf0 <= (in_i == '0) && (in_q == '0);
  end

  for (genvar k = 0; k < ITER; k++) begin : g_it
    localparam logic signed [ZW-1:0] ALPHA =
      ZW'($rtoi($atan(2.0 ** (-k)) / PI * (2.0 ** ZF) + 0.5));
    logic signed [XW-1:0] xi, yi, xo, yo;
    logic signed [ZW-1:0] zi, zo;
    logic                 vi, zfi, vo, zfo, yneg;

    if (k == 0) begin : g_src
      assign xi = x0; assign yi = y0; assign zi = z0;
      assign vi = v0; assign zfi = zf0;
    end else begin : g_src
      assign xi = g_it[k-1].xo; assign yi = g_it[k-1].yo; assign zi = g_it[k-1].zo;
      assign vi = g_it[k-1].vo; assign zfi = g_it[k-1].zfo;
    end

    assign yneg = yi[XW-1];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) vo <= 1'b0;
      else        vo <= vi;

    always_ff @(posedge clk) begin
      xo  <= yneg ? xi - (yi >>> k) : xi + (yi >>> k);
      yo  <= yneg ? yi + (xi >>> k) : yi - (xi >>> k);
      zo  <= yneg ? zi - ALPHA : zi + ALPHA;
      zfo <= zfi;
    end
  end

  logic signed [XW-1:0] xl, xm;
  logic signed [ZW-1:0] zl;
  logic                 vl, zfl;
  assign xl  = g_it[ITER-1].xo;
  assign zl  = g_it[ITER-1].zo;
  assign vl  = g_it[ITER-1].vo;
  assign zfl = g_it[ITER-1].zfo;

  if (MAG_SCALE != 0) begin : g_gain
    logic signed [XW-1:0] m0, m1, m2, m3;
    assign m0 = xl >>> 1;
    assign m1 = m0 + (m0 >>> 2);
    assign m2 = m1 - (m1 >>> 5);
    assign m3 = m2 + (m2 >>> 8);
    assign xm = m3 - (m3 >>> 10);
  end else begin : g_gain
    assign xm = xl;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vl;

  always_ff @(posedge clk) begin
    out_phase <= zfl ? '0 : PW'((zl + ZRND) >>> ZG);
    out_mag   <= zfl ? '0 : MW'((xm + XRND) >>> GB);
  end
endmodule

// File: rtl/cordic_phase_det_chk.sv
module cordic_phase_det_chk #(
  parameter int IW  = 16,
  parameter int PW  = 18,
  parameter int LAT = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic signed [IW-1:0] in_i,
  input logic signed [IW-1:0] in_q,
  input logic                 out_valid,
  input logic signed [PW-1:0] out_phase,
  input logic [IW+1:0]        out_mag
);
  localparam int ONE = 2 ** (PW - 2);

  logic [LAT-1:0] vq, zq, nq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vq <= '0; zq <= '0; nq <= '0;
    end else begin
      vq <= {vq[LAT-2:0], in_valid};
      zq <= {zq[LAT-2:0], in_valid && in_i == '0 && in_q == '0};
      nq <= {nq[LAT-2:0], in_valid && in_i[IW-1] && in_q == '0};
    end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vq[LAT-1]);

  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_phase) <= ONE + 2 && int'(out_phase) >= -ONE - 2));

  p_negaxis_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && nq[LAT-1] |-> int'(out_phase) >= ONE - 2);

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && zq[LAT-1] |-> out_phase == '0 && out_mag == '0);
endmodule

bind cordic_phase_det cordic_phase_det_chk #(.IW(IW), .PW(PW), .LAT(ITER + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
  .out_valid(out_valid), .out_phase(out_phase), .out_mag(out_mag)
);

// File: tb/cordic_phase_det_tb.sv
module cordic_phase_det_tb_top;
  localparam int IW = 16, PW = 18, ITER = 18, LAT = ITER + 2;
  localparam real PI = 3.14159265358979323846;
  localparam real SHIFT_GAIN = 0.5 * 1.25 * (1.0 - 1.0/32.0) * (1.0 + 1.0/256.0) * (1.0 - 1.0/1024.0);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [IW-1:0] in_i = '0, in_q = '0;
  logic out_valid, raw_valid;
  logic signed [PW-1:0] out_phase, raw_phase;
  logic [IW+1:0] out_mag, raw_mag;

  always #2 clk = ~clk;

  cordic_phase_det #(.IW(IW), .PW(PW), .ITER(ITER), .MAG_SCALE(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_phase(out_phase), .out_mag(out_mag));

  cordic_phase_det #(.IW(IW), .PW(PW), .ITER(ITER), .MAG_SCALE(0)) dut_raw_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(raw_valid), .out_phase(raw_phase), .out_mag(raw_mag));

  typedef struct { int c; int i; int q; string tag; } item_t;
  item_t pend[$];
  int cyc = 0, total = 0, bad = 0;
  real kgain;

  initial begin
    kgain = 1.0;
    for (int k = 0; k < ITER; k++) kgain = kgain * $sqrt(1.0 + 2.0 ** (-2*k));
  end

  always @(posedge clk) cyc <= cyc + 1;

  function automatic real absr(real v); return v < 0.0 ? -v : v; endfunction

  task automatic chk_phase(string tag, int i, int q, int got);
    real e;
    total++;
    if (i == 0 && q == 0) e = 0.0;
    else e = $atan2(real'(q), real'(i)) / PI * (2.0 ** (PW-2));
    if ((tag == "R5" && got != 0) || absr(real'(got) - e) > 2.0) begin
      bad++;
      $display("FAIL %s phase i=%0d q=%0d actual=%0d expected=%f", tag, i, q, got, e);
    end
  endtask

  task automatic chk_mag(string tag, int i, int q, int got, real g);
    real e;
    e = $sqrt(real'(i)*real'(i) + real'(q)*real'(q)) * g;
    total++;
    if (absr(real'(got) - e) > 2.0 + e / 4096.0) begin
      bad++;
      $display("FAIL %s magnitude i=%0d q=%0d actual=%0d expected=%f", tag, i, q, got, e);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit due;
    due = pend.size() > 0 && pend[0].c + LAT - 1 == cyc;
    total++;
    if (out_valid !== due || raw_valid !== due) begin
      bad++;
      $display("FAIL R1 out_valid actual=%b/%b expected=%b cycle=%0d", out_valid, raw_valid, due, cyc);
    end
    if (due) begin
      item_t it;
      it = pend.pop_front();
      chk_phase(it.tag, it.i, it.q, int'(out_phase));
      chk_phase(it.tag, it.i, it.q, int'(raw_phase));
      chk_mag(it.tag == "R5" ? "R5" : "R7", it.i, it.q, int'(out_mag), kgain * SHIFT_GAIN);
      chk_mag(it.tag == "R5" ? "R5" : "R6", it.i, it.q, int'(raw_mag), kgain);
    end
  end

  task automatic put(int i, int q, string tag);
    item_t it;
    in_valid = 1'b1; in_i = IW'(i); in_q = IW'(q);
    it.c = cyc + 1; it.i = i; it.q = q; it.tag = tag;
    pend.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || raw_valid !== 1'b0) begin
      bad++;
      $display("FAIL R8 reset out_valid actual=%b/%b expected=0", out_valid, raw_valid);
    end
    rst_n = 1'b1;
    idle(2);

    put(0, 0, "R5");                idle(3);
    put(20000, 0, "R2");            idle(1);
    put(0, 20000, "R2");
    put(0, -20000, "R2");
    put(-20000, 0, "R4");
    put(-32768, 0, "R4");
    put(-5000, 0, "R4");            idle(5);
    put(0, -32768, "R3");
    put(-32768, -32768, "R3");
    put(-32768, 32767, "R3");
    put(32767, -32768, "R3");
    put(32767, 32767, "R2");
    put(-4096, 1, "R3");
    put(-4096, -1, "R3");
    put(-30000, -7, "R3");
    put(0, 0, "R5");
    put(-12000, 9000, "R3");        idle(LAT + 3);

    for (int n = 0; n < 400; n++) begin
      int i, q;
      do begin
        i = int'($urandom_range(0, 65535)) - 32768;
        q = int'($urandom_range(0, 65535)) - 32768;
      end while (real'(i)*real'(i) + real'(q)*real'(q) < 4096.0*4096.0);
      put(i, q, "R9");
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 4)));
    end
    idle(LAT + 5);

    total++;
    if (pend.size() != 0) begin
      bad++;
      $display("FAIL R1 results missing actual=%0d expected=0", pend.size());
    end
    finish_run();
  end

  initial begin
    repeat (60000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    finish_run();
  end
endmodule